// File: doc/BRIEF.md
# Receive Frame Buffer Unpacker

This block pulls one received Ethernet frame out of a 16-bit packet memory and turns it into a byte stream. A stored frame is laid out as a status word, a byte-count word, the payload words, and a trailing control word. The count field carries a fixed six-byte overhead, which the block removes. The control word can hold one more payload byte in its low half; a flag bit says whether it does. The block asks for the frame buffer to be freed after every frame it visits. It waits for the memory manager to finish that release before it goes on.

Software or a host engine pulses `start`. The block then works through the pending frames in the order the queue presents them. A frame that is damaged is freed with no output, and so is a frame whose payload length comes out as zero. In both cases the next pending frame is tried. The first frame that yields a non-zero length is streamed out. A one-cycle `done` pulse then reports that length. If nothing is pending, or every visited frame had length zero, `done` reports length 0.

Top module: `rx_frame_unpacker`

## Requirements
- R1: If the status word (offset 0) has any of bits 15, 13, 11 or 10 set, the frame yields no bytes and length 0, and it is still released. All other status bits are ignored.
- R2: The payload length L is bits [10:0] of the count word (offset 1) minus 6, with a floor of 0. Bits [15:11] of the count word are ignored.
- R3: The block emits floor(L/2) payload words, read from offsets 2, 3, and so on. Each word gives its bits [7:0] first and then its bits [15:8].
- R4: The control word sits at offset 2+floor(L/2). If its bit 13 is set, its bits [7:0] are sent as one more byte after the words, and the reported length is L+1. Otherwise the reported length is L.
- R5: `out_last` is high on the final byte of a delivered frame, and on no other byte.
- R6: While `out_valid` is high and `out_ready` is low, the byte and the last flag stay unchanged.
- R7: After each visited frame, good or errored, `rel_req` pulses for exactly one cycle. No memory read and no further release is issued while `rel_busy` is high.
- R8: After a release, if the reported length was 0 and `frame_pending` is high, the block processes the next frame. Otherwise `done` pulses for one cycle with `done_len` set to that length. `done` is never high together with `out_valid`.
- R9: A `start` seen while `frame_pending` is low gives `done` with length 0, with no memory read and no release.
- R10: After reset, `out_valid`, `out_last`, `done`, `rel_req` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to fetch the next deliverable frame |
| frame_pending | input | 1 | At least one received frame is queued |
| frame_base | input | AW | Word address of the head frame |
| mem_rd_en | output | 1 | Read strobe to packet memory |
| mem_rd_addr | output | AW | Word address to read |
| mem_rd_data | input | WORD_W | Read data, valid one cycle after the strobe |
| rel_req | output | 1 | One-cycle request to free the head frame |
| rel_busy | input | 1 | Memory manager is still freeing |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | BYTE_W | Payload byte |
| out_last | output | 1 | Final byte of the frame |
| done | output | 1 | One-cycle completion pulse |
| done_len | output | CNT_W | Reported length, valid with `done` |

## Verification
The bench builds the block with a 10-bit word address and keeps every other parameter at its default. The small address space lets each frame sit in its own 64-word slot of a modelled memory. The count field is swept from 0 to 40 with both values of the odd flag. This covers the floor at zero and odd raw lengths. It also covers the cases with no payload word, only a trailing byte, or a single word. Short queues with errored, empty and good frames exercise the skip-and-retry path. Three patterns of sink back-pressure are used, and release busy windows last several cycles.

// File: rtl/rxfu_pkg.sv
package rxfu_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STAT_RD,
      ST_STAT_CHK,
      ST_CNT_RD,
      ST_CNT_CHK,
      ST_CTRL_RD,
      ST_CTRL_CHK,
      ST_WORD_RD,
      ST_WORD_LD,
      ST_DRAIN,
      ST_REL,
      ST_REL_WAIT,
      ST_DONE
   } unpack_state_e;

   typedef enum logic [1:0] {
      SEL_STAT,
      SEL_CNT,
      SEL_CTRL,
      SEL_WORD
   } addr_sel_e;

endpackage

// File: rtl/rxfu_flag_check.sv
module rxfu_flag_check #(
   parameter int WORD_W    = 16,
   parameter int ALN_BIT   = 15,
   parameter int CRC_BIT   = 13,
   parameter int LONG_BIT  = 11,
   parameter int SHORT_BIT = 10
) (
   input  logic [WORD_W-1:0] stat_word,
   output logic              bad_frame
);

   logic [WORD_W-1:0] err_mask;

   // one mask bit per status position, set when it matches any error flag
   for (genvar b = 0; b < WORD_W; b++) begin : g_mask
      assign err_mask[b] = (b == ALN_BIT) || (b == CRC_BIT) ||
                           (b == LONG_BIT) || (b == SHORT_BIT);
   end

   assign bad_frame = |(stat_word & err_mask);

endmodule

// File: rtl/rxfu_addr_sel.sv
module rxfu_addr_sel
   import rxfu_pkg::*;
#(
   parameter int AW    = 12,
   parameter int CNT_W = 11
) (
   input  logic [AW-1:0]    base,
   input  addr_sel_e        sel,
   input  logic [CNT_W-1:0] word_total,
   input  logic [CNT_W-1:0] word_idx,
   output logic [AW-1:0]    addr
);

   localparam logic [AW-1:0] HDR_WORDS = AW'(2);

   logic [AW-1:0] offset;

   always_comb begin
      unique case (sel)
         SEL_STAT: offset = '0;
         SEL_CNT:  offset = AW'(1);
         SEL_CTRL: offset = HDR_WORDS + AW'(word_total);
         default:  offset = HDR_WORDS + AW'(word_idx);
      endcase
   end

   assign addr = base + offset;

endmodule

// File: rtl/rxfu_byte_lane.sv
module rxfu_byte_lane #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   localparam int LANES = WORD_W / BYTE_W,
   localparam int LW    = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic [LW-1:0]     load_cnt,
   input  logic              load_last,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_last
);

   logic [WORD_W-1:0] word_q;
   logic [LW-1:0]     idx_q;
   logic [LW-1:0]     cnt_q;
   logic              last_q;
   logic              busy_q;
   logic              at_final;

   assign at_final  = (idx_q == LW'(cnt_q - 1'b1));
   assign out_valid = busy_q;
   assign out_data  = BYTE_W'(word_q >> (idx_q * BYTE_W));
   assign out_last  = busy_q & last_q & at_final;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
         cnt_q  <= '0;
         last_q <= 1'b0;
         busy_q <= 1'b0;
      end else if (load) begin
         word_q <= load_word;
         idx_q  <= '0;
         cnt_q  <= load_cnt;
         last_q <= load_last;
         busy_q <= 1'b1;
      end else if (busy_q && out_ready) begin
         if (at_final) busy_q <= 1'b0;
         else          idx_q  <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/rx_frame_unpacker.sv
module rx_frame_unpacker
   import rxfu_pkg::*;
#(
   parameter int AW        = 12,
   parameter int WORD_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 11,
   parameter int OVERHEAD  = 6,
   parameter int ALN_BIT   = 15,
   parameter int CRC_BIT   = 13,
   parameter int LONG_BIT  = 11,
   parameter int SHORT_BIT = 10,
   parameter int ODD_BIT   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              frame_pending,
   input  logic [AW-1:0]     frame_base,
   output logic              mem_rd_en,
   output logic [AW-1:0]     mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic              rel_req,
   input  logic              rel_busy,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_last,
   output logic              done,
   output logic [CNT_W-1:0]  done_len
);

   localparam int LANES = WORD_W / BYTE_W;
   localparam int LW    = $clog2(LANES + 1);
   localparam logic [CNT_W-1:0] OVH = CNT_W'(OVERHEAD);

   if (WORD_W % BYTE_W != 0 || LANES < 2) begin : g_bad_width
      $error("WORD_W must hold a whole number of bytes, at least two");
   end
   if (CNT_W > WORD_W) begin : g_bad_cnt
      $error("CNT_W must fit in a memory word");
   end
   if (ALN_BIT >= WORD_W || CRC_BIT >= WORD_W || LONG_BIT >= WORD_W ||
       SHORT_BIT >= WORD_W || ODD_BIT >= WORD_W) begin : g_bad_flag
      $error("flag bit positions must lie inside the memory word");
   end

   unpack_state_e     state_q;
   logic [AW-1:0]     base_q;
   logic [CNT_W-1:0]  len_q;
   logic [CNT_W-1:0]  words_left_q;
   logic [CNT_W-1:0]  word_idx_q;
   logic              tail_pend_q;
   logic [BYTE_W-1:0] tail_byte_q;

   logic              bad_frame;
   logic [CNT_W-1:0]  cnt_field;
   logic [CNT_W-1:0]  pay_len;
   addr_sel_e         sel;
   logic              lane_load;
   logic [WORD_W-1:0] lane_word;
   logic [LW-1:0]     lane_cnt;
   logic              lane_last;
   logic              lane_busy;
   logic              drain_idle;

   rxfu_flag_check #(
      .WORD_W   (WORD_W),
      .ALN_BIT  (ALN_BIT),
      .CRC_BIT  (CRC_BIT),
      .LONG_BIT (LONG_BIT),
      .SHORT_BIT(SHORT_BIT)
   ) u_flags (
      .stat_word(mem_rd_data),
      .bad_frame(bad_frame)
   );

   rxfu_addr_sel #(
      .AW   (AW),
      .CNT_W(CNT_W)
   ) u_addr (
      .base      (base_q),
      .sel       (sel),
      .word_total(words_left_q),
      .word_idx  (word_idx_q),
      .addr      (mem_rd_addr)
   );

   rxfu_byte_lane #(
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W)
   ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (lane_load),
      .load_word(lane_word),
      .load_cnt (lane_cnt),
      .load_last(lane_last),
      .out_ready(out_ready),
      .out_valid(lane_busy),
      .out_data (out_data),
      .out_last (out_last)
   );

   assign out_valid = lane_busy;

   // byte count field and overhead removal with a floor at zero
   assign cnt_field = mem_rd_data[CNT_W-1:0];
   assign pay_len   = (cnt_field >= OVH) ? (cnt_field - OVH) : '0;

   always_comb begin
      unique case (state_q)
         ST_STAT_RD: sel = SEL_STAT;
         ST_CNT_RD:  sel = SEL_CNT;
         ST_CTRL_RD: sel = SEL_CTRL;
         default:    sel = SEL_WORD;
      endcase
   end

   assign mem_rd_en = (state_q == ST_STAT_RD) || (state_q == ST_CNT_RD) ||
                      (state_q == ST_CTRL_RD) || (state_q == ST_WORD_RD);
   assign rel_req   = (state_q == ST_REL);
   assign done      = (state_q == ST_DONE);
   assign done_len  = len_q;

   assign drain_idle = (state_q == ST_DRAIN) && !lane_busy;

   // lane is loaded with a fresh payload word or with the trailing odd byte
   always_comb begin
      if (state_q == ST_WORD_LD) begin
         lane_load = 1'b1;
         lane_word = mem_rd_data;
         lane_cnt  = LW'(LANES);
         lane_last = (words_left_q == CNT_W'(1)) && !tail_pend_q;
      end else begin
         lane_load = drain_idle && (words_left_q == '0) && tail_pend_q;
         lane_word = WORD_W'(tail_byte_q);
         lane_cnt  = LW'(1);
         lane_last = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         base_q       <= '0;
         len_q        <= '0;
         words_left_q <= '0;
         word_idx_q   <= '0;
         tail_pend_q  <= 1'b0;
         tail_byte_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  len_q <= '0;
                  if (frame_pending) begin
                     base_q  <= frame_base;
                     state_q <= ST_STAT_RD;
                  end else begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_STAT_RD: state_q <= ST_STAT_CHK;
            ST_STAT_CHK: begin
               if (bad_frame) begin
                  len_q        <= '0;
                  words_left_q <= '0;
                  tail_pend_q  <= 1'b0;
                  state_q      <= ST_REL;
               end else begin
                  state_q <= ST_CNT_RD;
               end
            end
            ST_CNT_RD: state_q <= ST_CNT_CHK;
            ST_CNT_CHK: begin
               len_q        <= pay_len;
               words_left_q <= pay_len >> 1;
               state_q      <= ST_CTRL_RD;
            end
            ST_CTRL_RD: state_q <= ST_CTRL_CHK;
            ST_CTRL_CHK: begin
               tail_pend_q <= mem_rd_data[ODD_BIT];
               tail_byte_q <= mem_rd_data[BYTE_W-1:0];
               if (mem_rd_data[ODD_BIT]) len_q <= len_q + 1'b1;
               word_idx_q  <= '0;
               state_q     <= (words_left_q != '0) ? ST_WORD_RD : ST_DRAIN;
            end
            ST_WORD_RD: state_q <= ST_WORD_LD;
            ST_WORD_LD: begin
               words_left_q <= words_left_q - 1'b1;
               word_idx_q   <= word_idx_q + 1'b1;
               state_q      <= ST_DRAIN;
            end
            ST_DRAIN: begin
               if (!lane_busy) begin
                  if (words_left_q != '0) state_q     <= ST_WORD_RD;
                  else if (tail_pend_q)   tail_pend_q <= 1'b0;
                  else                    state_q     <= ST_REL;
               end
            end
            ST_REL: state_q <= ST_REL_WAIT;
            ST_REL_WAIT: begin
               if (!rel_busy) begin
                  if ((len_q == '0) && frame_pending) begin
                     base_q  <= frame_base;
                     state_q <= ST_STAT_RD;
                  end else begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rxfu_unpacker_chk.sv
module rxfu_unpacker_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic              rel_req,
   input logic              rel_busy,
   input logic              out_valid,
   input logic              out_ready,
   input logic [BYTE_W-1:0] out_data,
   input logic              out_last,
   input logic              done
);

   // R6: a byte that is not accepted holds its value and last flag
   a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R7: a release request lasts a single cycle
   a_r7_rel_single: assert property (@(posedge clk) disable iff (!rst_n)
      rel_req |=> !rel_req);

   // R7: nothing is read or released while a release is in progress
   a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rel_busy |-> (!mem_rd_en && !rel_req));

   // R8: completion is a single-cycle pulse
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: completion never overlaps an outstanding byte
   a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);

endmodule

bind rx_frame_unpacker rxfu_unpacker_chk #(.BYTE_W(BYTE_W)) chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd_en(mem_rd_en),
   .rel_req  (rel_req),
   .rel_busy (rel_busy),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .out_last (out_last),
   .done     (done)
);

// File: tb/rx_frame_unpacker_test.sv
module rx_frame_unpacker_test;

   localparam int AW    = 10;
   localparam int CNT_W = 11;
   localparam int SLOT  = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              frame_pending;
   logic [AW-1:0]     frame_base;
   logic              mem_rd_en;
   logic [AW-1:0]     mem_rd_addr;
   logic [15:0]       mem_rd_data = '0;
   logic              rel_req;
   logic              rel_busy;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [7:0]        out_data;
   logic              out_last;
   logic              done;
   logic [CNT_W-1:0]  done_len;

   always #2 clk = ~clk;

   rx_frame_unpacker #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .frame_pending(frame_pending), .frame_base(frame_base),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .rel_req(rel_req), .rel_busy(rel_busy),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .done(done), .done_len(done_len)
   );

   logic [15:0] mem [1024];
   int q_f [8];
   int q_o [8];
   int q_e [8];
   int q_n = 0;
   int head = 0;
   int busy_cnt = 0;
   int rel_cnt = 0;
   int rd_cnt = 0;
   int got_b [64];
   int got_l [64];
   int got_n = 0;
   int got_done = 0;
   int got_len = 0;
   int rdy_mode = 0;
   logic [7:0] lfsr = 8'h5B;
   int nchk = 0;
   int nfail = 0;

   assign frame_pending = (head < q_n);
   assign frame_base    = frame_pending ? AW'(head * SLOT) : '0;
   assign rel_busy      = (busy_cnt != 0);

   // packet memory model with a one-cycle read latency, plus release handling
   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= mem[mem_rd_addr];
         rd_cnt      <= rd_cnt + 1;
      end
      if (rel_req) begin
         head     <= head + 1;
         rel_cnt  <= rel_cnt + 1;
         busy_cnt <= 3;
      end else if (busy_cnt != 0) begin
         busy_cnt <= busy_cnt - 1;
      end
   end

   // sink: choose ready for the coming edge, then log the transfer it makes
   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rdy_mode)
         0:       out_ready = 1'b1;
         1:       out_ready = ~out_ready;
         default: out_ready = lfsr[0];
      endcase
      if (out_valid && out_ready && got_n < 64) begin
         got_b[got_n] = int'(out_data);
         got_l[got_n] = int'(out_last);
         got_n = got_n + 1;
      end
      if (done) begin
         got_done = got_done + 1;
         got_len  = int'(done_len);
      end
   end

   function automatic logic [7:0] dlo(int slot, int i);
      return 8'(slot * 37 + i * 2 + 5);
   endfunction
   function automatic logic [7:0] dhi(int slot, int i);
      return 8'(slot * 37 + i * 2 + 6) ^ 8'h5A;
   endfunction
   function automatic logic [7:0] tailb(int slot);
      return 8'(slot * 11 + 195);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // errmask uses status bits 15/13/11/10; bits 14 and 12 are set as noise
   task automatic add_frame(input int f, input int o, input int e);
      int b = q_n * SLOT;
      int nw = ((f >= 6) ? f - 6 : 0) / 2;
      mem[b]     = 16'h5000 | 16'(e);
      mem[b + 1] = 16'hF800 | 16'(f);
      for (int i = 0; i < nw; i++) mem[b + 2 + i] = {dhi(q_n, i), dlo(q_n, i)};
      mem[b + 2 + nw] = 16'h5000 | (o != 0 ? 16'h2000 : 16'h0000) | 16'(tailb(q_n));
      q_f[q_n] = f; q_o[q_n] = o; q_e[q_n] = e;
      q_n++;
   endtask

   task automatic run(input string tag);
      int exp_b [64];
      int exp_n = 0;
      int exp_len = 0;
      int exp_rel = 0;
      int t = 0;
      int err_n = 0;
      got_n = 0; got_done = 0; got_len = -1; rel_cnt = 0; rd_cnt = 0; head = 0;
      for (int fi = 0; fi < q_n; fi++) begin
         int len_l;
         exp_rel++;
         if (q_e[fi] != 0) begin
            exp_len = 0;
            continue;
         end
         len_l = (q_f[fi] >= 6) ? q_f[fi] - 6 : 0;
         exp_len = len_l + q_o[fi];
         exp_n = 0;
         for (int i = 0; i < len_l / 2; i++) begin
            exp_b[exp_n++] = int'(dlo(fi, i));
            exp_b[exp_n++] = int'(dhi(fi, i));
         end
         if (q_o[fi] != 0) exp_b[exp_n++] = int'(tailb(fi));
         if (exp_len > 0) break;
      end
      if (exp_len == 0) exp_n = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (got_done == 0 && t < 6000) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      check(got_done == 1, {"R8 done pulse count ", tag}, got_done, 1);
      check(got_len == exp_len, {"R2 R4 R8 reported length ", tag}, got_len, exp_len);
      check(got_n == exp_n, {"R1 R3 byte count ", tag}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
         if (got_b[i] != exp_b[i]) err_n++;
      check(err_n == 0, {"R3 R4 byte values ", tag}, err_n, 0);
      err_n = 0;
      for (int i = 0; i < got_n; i++)
         if (got_l[i] != ((i == got_n - 1) ? 1 : 0)) err_n++;
      check(err_n == 0, {"R5 last flag placement ", tag}, err_n, 0);
      check(rel_cnt == exp_rel, {"R7 R8 release count ", tag}, rel_cnt, exp_rel);
      q_n = 0;
      head = 0;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !out_last && !done && !rel_req && !mem_rd_en,
            "R10 outputs after reset",
            int'({out_valid, out_last, done, rel_req, mem_rd_en}), 0);

      // R9: nothing pending
      run("R9 empty queue");
      check(rd_cnt == 0, "R9 no reads with empty queue", rd_cnt, 0);

      // R2 R3 R4 R5: sweep count field and odd flag, rotating sink patterns
      for (int f = 0; f <= 40; f++) begin
         for (int o = 0; o < 2; o++) begin
            rdy_mode = (f + o) % 3;
            add_frame(f, o, 0);
            run($sformatf("R2 sweep f=%0d o=%0d", f, o));
         end
      end

      // R1: each error flag alone, then a good frame behind it
      for (int k = 0; k < 4; k++) begin
         int m = (k == 0) ? 16'h8000 : (k == 1) ? 16'h2000 : (k == 2) ? 16'h0800 : 16'h0400;
         rdy_mode = k % 3;
         add_frame(20, 1, m);
         add_frame(16, 0, 0);
         run($sformatf("R1 flag mask %0h then good", m));
      end

      // R1: a lone errored frame reports zero
      add_frame(30, 1, 16'h8400);
      run("R1 lone errored frame");

      // R8: errored, empty good, then good odd frame
      rdy_mode = 2;
      add_frame(12, 0, 16'h2000);
      add_frame(6, 0, 0);
      add_frame(14, 1, 0);
      run("R8 skip chain");

      // R8: delivery stops at the first non-empty frame
      rdy_mode = 1;
      add_frame(10, 0, 0);
      add_frame(12, 0, 0);
      run("R8 stop after first good");

      // R8: empty good frames only
      add_frame(6, 0, 0);
      add_frame(3, 0, 0);
      run("R8 all empty");

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule